// File: doc/BRIEF.md
# Circular trace capture buffer

This block is the last stop of a trace path. Trace words arrive on a valid/ready stream with a trigger sideband. While capture runs, each accepted word goes into an internal circular RAM at the write pointer. When the pointer rolls past the last entry, a sticky full flag records that the oldest data now sits at the write pointer. Software sees the block through a simple register bus. It can read the build-time depth, a status word, both pointers, a post-trigger countdown, a capture-enable bit and a flush control/status pair. It drains the RAM through a read-data register that steps the read pointer on every read. A write-data register lets software fill or clear the RAM through the same pointer.

There are two ways to end a capture. The first is stop-on-trigger: after a trigger beat, the block keeps a programmed number of further words and then refuses input. The second is a manual flush: a flush request stays pending while beats are still being accepted. It completes on the first cycle with no accepted beat and, if stop-on-flush is set, halts capture. A fresh rising edge of the capture-enable bit re-arms the block. Register reads are combinational within the request cycle. All writes and read side effects take effect at the clock edge.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, the read pointer, write pointer, status word, control word, trigger count and flush control all read 0, and the flush status word reads 2 (bit 1 set).
- R2: The depth register (offset 0x004) reads the DEPTH parameter, with bit 31 always 0.
- R3: A bus write to the write-data register (0x024) stores the data at the write pointer and advances the pointer (0x018), wrapping from DEPTH-1 to 0. A write to 0x018 loads the pointer.
- R4: A bus read of the read-data register (0x010) returns the word at the read pointer (0x014) in the same cycle and advances the pointer, wrapping at DEPTH. A write to 0x014 loads the pointer.
- R5: Status bit 0 (full) sets when the write pointer wraps from DEPTH-1 to 0. It stays set until the write-pointer register is written, which clears it.
- R6: trc_ready is high only while control bit 0 (capture enable) is 1, capture is not stopped, and no bus write to 0x024 or 0x018 occurs in that cycle. Each beat accepted this way is stored at the write pointer.
- R7: With flush-control bit 13 (stop on trigger) set, an accepted beat carrying trc_trig is stored, and then exactly N more beats are stored, where N is the trigger count (0x01C). The count decrements once per stored beat. Capture then stops, and status bit 2 reads 1.
- R8: With bit 13 clear, a trigger beat only sets status bit 1 (triggered). Capture continues and the trigger count is left unchanged.
- R9: Writing flush-control bit 6 starts a flush, and bit 6 reads 1 while it is pending. The flush completes, and bit 6 clears, on the first later cycle with no accepted beat. If flush-control bit 12 (stop on flush) is set, capture stops at that point.
- R10: Flush status bit 1 (offset 0x300) reads 1 whenever capture is disabled or stopped, and 0 otherwise.
- R11: A control write that raises bit 0 from 0 to 1 clears the stopped and triggered flags and re-opens trc_ready.
- R12: Status bit 3 reads 1 when the write pointer is not a multiple of FRAME_WORDS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trig | input | 1 | Trigger marker for the current beat |
| trc_ready | output | 1 | Block accepts the current beat |

## Verification
A wrong pointer shows at the ports right away. The next pointer-register read returns the wrong value, and the next drain through the read-data register returns words out of order. Because the bench model tracks both pointers and the RAM contents and compares every read, the mismatch is reported in that very cycle. A stuck or early stop flag changes trc_ready in the same cycle, and trc_ready is compared on every clock. A miscounted trigger countdown therefore surfaces one beat early or late as a ready mismatch. A flush that never completes shows as bit 6 still set on the next flush-control read.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

  localparam int REG_W = 32;
  localparam int ADDR_W = 12;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_RDAT  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RPTR  = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_WPTR  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_TCNT  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_WDAT  = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_FCTRL = 12'h304;

  // Field positions
  localparam int CTRL_EN_BIT    = 0;
  localparam int FC_FLUSH_BIT   = 6;
  localparam int FC_STOPFL_BIT  = 12;
  localparam int FC_STOPTRG_BIT = 13;
  localparam int FS_HALT_BIT    = 1;
  localparam int ST_FULL_BIT    = 0;
  localparam int ST_TRIG_BIT    = 1;
  localparam int ST_STOP_BIT    = 2;
  localparam int ST_UNAL_BIT    = 3;

  typedef enum logic [3:0] {
    RS_NONE, RS_DEPTH, RS_STAT, RS_RDAT, RS_RPTR, RS_WPTR,
    RS_TCNT, RS_CTRL, RS_WDAT, RS_FSTAT, RS_FCTRL
  } reg_sel_e;

  typedef struct packed {
    logic cap_en;
    logic stopped;
    logic trig_seen;
    logic flush_pend;
    logic stop_on_fl;
    logic stop_on_trg;
  } ctl_state_t;

  function automatic reg_sel_e decode_reg(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_DEPTH: s = RS_DEPTH;
      OFS_STAT:  s = RS_STAT;
      OFS_RDAT:  s = RS_RDAT;
      OFS_RPTR:  s = RS_RPTR;
      OFS_WPTR:  s = RS_WPTR;
      OFS_TCNT:  s = RS_TCNT;
      OFS_CTRL:  s = RS_CTRL;
      OFS_WDAT:  s = RS_WDAT;
      OFS_FSTAT: s = RS_FSTAT;
      OFS_FCTRL: s = RS_FCTRL;
      default:   s = RS_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/trace_ring_rstsync.sv
module trace_ring_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/trace_ring_ptr.sv
module trace_ring_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr_q,
  output logic          wrap
);
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load | adv;
    ptr_d  = load ? load_val : ptr_q + 1'b1;
    wrap   = adv & ~load & (ptr_q == {AW{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/trace_ring_mem.sv
module trace_ring_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cell_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic cell_en;
    assign cell_en = we & (waddr == AW'(gi));
    always_ff @(posedge clk) begin
      if (cell_en) cell_q[gi] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/trace_ring_ctrl.sv
module trace_ring_ctrl
  import trace_ring_pkg::*;
#(
  parameter int TRIG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_wval,
  input  logic              fctl_wr,
  input  logic              fctl_flush,
  input  logic              fctl_stop_fl,
  input  logic              fctl_stop_trg,
  input  logic              tcnt_wr,
  input  logic [TRIG_W-1:0] tcnt_wval,
  input  logic              acc,
  input  logic              trig_in,
  output ctl_state_t        st_q,
  output logic [TRIG_W-1:0] tcnt_q
);
  ctl_state_t        st_d;
  logic              st_en;
  logic [TRIG_W-1:0] tcnt_d;
  logic              tcnt_en;
  logic              en_rise, trig_hit, count_beat, flush_done, stop_set;

  always_comb begin
    en_rise    = ctrl_wr & ctrl_wval & ~st_q.cap_en;
    trig_hit   = acc & trig_in & ~st_q.trig_seen;
    count_beat = acc & st_q.trig_seen & st_q.stop_on_trg;
    flush_done = st_q.flush_pend & ~acc;
    stop_set   = (trig_hit & st_q.stop_on_trg & (tcnt_q == '0))
               | (count_beat & (tcnt_q == TRIG_W'(1)))
               | (flush_done & st_q.stop_on_fl);

    st_d = st_q;
    if (ctrl_wr)    st_d.cap_en     = ctrl_wval;
    if (stop_set)   st_d.stopped    = 1'b1;
    if (trig_hit)   st_d.trig_seen  = 1'b1;
    if (en_rise) begin
      st_d.stopped   = 1'b0;
      st_d.trig_seen = 1'b0;
    end
    if (flush_done) st_d.flush_pend = 1'b0;
    if (fctl_wr) begin
      st_d.stop_on_fl  = fctl_stop_fl;
      st_d.stop_on_trg = fctl_stop_trg;
      if (fctl_flush) st_d.flush_pend = 1'b1;
    end
    st_en = ctrl_wr | fctl_wr | acc | st_q.flush_pend;

    tcnt_d  = tcnt_q;
    tcnt_en = tcnt_wr | count_beat;
    if (tcnt_wr)                      tcnt_d = tcnt_wval;
    else if (tcnt_q != '0)            tcnt_d = tcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (tcnt_en) tcnt_q <= tcnt_d;
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trace_ring_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int TRIG_W      = 16,
  parameter int FRAME_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trig,
  output logic        trc_ready
);
  localparam int AW = $clog2(DEPTH);

  logic              srst_n;
  reg_sel_e          sel;
  logic              bw, br;
  logic              wdat_wr, wptr_wr, rptr_wr, rdat_rd, tcnt_wr, ctrl_wr, fctl_wr;
  logic              acc, mem_we;
  logic [REG_W-1:0]  mem_wdata, mem_rdata;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic              wrap;
  logic              full_q, full_d, full_en;
  logic              unaligned;
  ctl_state_t        st_q;
  logic [TRIG_W-1:0] tcnt_q;

  trace_ring_rstsync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  always_comb begin
    sel     = decode_reg(bus_addr);
    bw      = bus_req & bus_wr;
    br      = bus_req & ~bus_wr;
    wdat_wr = bw & (sel == RS_WDAT);
    wptr_wr = bw & (sel == RS_WPTR);
    rptr_wr = bw & (sel == RS_RPTR);
    tcnt_wr = bw & (sel == RS_TCNT);
    ctrl_wr = bw & (sel == RS_CTRL);
    fctl_wr = bw & (sel == RS_FCTRL);
    rdat_rd = br & (sel == RS_RDAT);
    trc_ready = st_q.cap_en & ~st_q.stopped & ~(wdat_wr | wptr_wr);
    acc       = trc_valid & trc_ready;
    mem_we    = wdat_wr | acc;
    mem_wdata = wdat_wr ? bus_wdata : trc_data;
  end

  trace_ring_mem #(.DEPTH(DEPTH), .DW(REG_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wptr_q), .wdata(mem_wdata),
    .raddr(rptr_q), .rdata(mem_rdata)
  );

  trace_ring_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(srst_n), .load(wptr_wr), .load_val(bus_wdata[AW-1:0]),
    .adv(mem_we), .ptr_q(wptr_q), .wrap(wrap)
  );

  logic rptr_wrap_unused;
  trace_ring_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .rst_n(srst_n), .load(rptr_wr), .load_val(bus_wdata[AW-1:0]),
    .adv(rdat_rd), .ptr_q(rptr_q), .wrap(rptr_wrap_unused)
  );

  trace_ring_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wval(bus_wdata[CTRL_EN_BIT]),
    .fctl_wr(fctl_wr), .fctl_flush(bus_wdata[FC_FLUSH_BIT]),
    .fctl_stop_fl(bus_wdata[FC_STOPFL_BIT]), .fctl_stop_trg(bus_wdata[FC_STOPTRG_BIT]),
    .tcnt_wr(tcnt_wr), .tcnt_wval(bus_wdata[TRIG_W-1:0]),
    .acc(acc), .trig_in(trc_trig), .st_q(st_q), .tcnt_q(tcnt_q)
  );

  // Full flag: set on wrap, cleared by a write-pointer load
  always_comb begin
    full_en = wptr_wr | wrap;
    full_d  = ~wptr_wr;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       full_q <= 1'b0;
    else if (full_en)  full_q <= full_d;
  end

  assign unaligned = (int'(wptr_q) % FRAME_WORDS) != 0;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (sel)
      RS_DEPTH: bus_rdata = {1'b0, 31'(DEPTH)};
      RS_STAT: begin
        bus_rdata[ST_FULL_BIT] = full_q;
        bus_rdata[ST_TRIG_BIT] = st_q.trig_seen;
        bus_rdata[ST_STOP_BIT] = st_q.stopped;
        bus_rdata[ST_UNAL_BIT] = unaligned;
      end
      RS_RDAT:  bus_rdata = mem_rdata;
      RS_RPTR:  bus_rdata = REG_W'(rptr_q);
      RS_WPTR:  bus_rdata = REG_W'(wptr_q);
      RS_TCNT:  bus_rdata = REG_W'(tcnt_q);
      RS_CTRL:  bus_rdata[CTRL_EN_BIT] = st_q.cap_en;
      RS_FSTAT: bus_rdata[FS_HALT_BIT] = ~st_q.cap_en | st_q.stopped;
      RS_FCTRL: begin
        bus_rdata[FC_FLUSH_BIT]   = st_q.flush_pend;
        bus_rdata[FC_STOPFL_BIT]  = st_q.stop_on_fl;
        bus_rdata[FC_STOPTRG_BIT] = st_q.stop_on_trg;
      end
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk
  import trace_ring_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          srst_n,
  input logic          bus_req,
  input logic          bus_wr,
  input logic [11:0]   bus_addr,
  input logic          wd_b0,
  input logic          wd_b6,
  input logic [AW-1:0] wptr_q,
  input logic [AW-1:0] rptr_q,
  input logic          full_q,
  input logic          cap_en,
  input logic          stopped,
  input logic          flush_pend,
  input logic          trc_valid,
  input logic          trc_ready
);
  logic w_any, r_any;
  assign w_any = bus_req & bus_wr;
  assign r_any = bus_req & ~bus_wr;

  a_r3_wptr_step: assert property (@(posedge clk) disable iff (!srst_n)
    (w_any && bus_addr == OFS_WDAT) |=> (wptr_q == $past(wptr_q) + 1'b1));

  a_r4_rptr_step: assert property (@(posedge clk) disable iff (!srst_n)
    (r_any && bus_addr == OFS_RDAT) |=> (rptr_q == $past(rptr_q) + 1'b1));

  a_r5_full_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (full_q && !(w_any && bus_addr == OFS_WPTR)) |=> full_q);

  a_r6_ready_gate: assert property (@(posedge clk) disable iff (!srst_n)
    trc_ready |-> (cap_en && !stopped));

  a_r7_stop_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (stopped && !(w_any && bus_addr == OFS_CTRL && wd_b0 && !cap_en)) |=> stopped);

  a_r9_flush_done: assert property (@(posedge clk) disable iff (!srst_n)
    (flush_pend && !(trc_valid && trc_ready) && !(w_any && bus_addr == OFS_FCTRL && wd_b6))
      |=> !flush_pend);
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.AW(AW)) u_chk (
  .clk(clk), .srst_n(srst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wd_b0(bus_wdata[0]), .wd_b6(bus_wdata[6]),
  .wptr_q(wptr_q), .rptr_q(rptr_q), .full_q(full_q),
  .cap_en(st_q.cap_en), .stopped(st_q.stopped), .flush_pend(st_q.flush_pend),
  .trc_valid(trc_valid), .trc_ready(trc_ready)
);

// File: tb/trace_ring_sink_bench.sv
module trace_ring_sink_bench;
  localparam int DEPTH  = 16;
  localparam int TRIG_W = 8;
  localparam int FRAME  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        trc_valid, trc_trig, trc_ready;
  logic [31:0] trc_data;

  always #5 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH), .TRIG_W(TRIG_W), .FRAME_WORDS(FRAME)) u_trace_ring_sink (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trig(trc_trig),
    .trc_ready(trc_ready)
  );

  int n_chk = 0;
  int n_err = 0;
  int wd = 0;
  logic [31:0] last_rd;

  // Behavioural reference state
  logic [31:0] m_ram [DEPTH];
  int m_rptr = 0, m_wptr = 0, m_cnt = 0;
  bit m_full = 0, m_en = 0, m_stop = 0, m_trig = 0, m_pend = 0, m_b12 = 0, m_b13 = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_ready();
    bit blk;
    blk = bus_req && bus_wr && (bus_addr == 12'h024 || bus_addr == 12'h018);
    return m_en && !m_stop && !blk;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      12'h004: v = 32'(DEPTH);
      12'h00C: v = {28'd0, (m_wptr % FRAME) != 0, m_stop, m_trig, m_full};
      12'h010: v = m_ram[m_rptr];
      12'h014: v = 32'(m_rptr);
      12'h018: v = 32'(m_wptr);
      12'h01C: v = 32'(m_cnt);
      12'h020: v = {31'd0, m_en};
      12'h300: v = {30'd0, (!m_en || m_stop), 1'b0};
      12'h304: begin v[13] = m_b13; v[12] = m_b12; v[6] = m_pend; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic m_step();
    bit bw, br, acc, adv;
    int n_cnt;
    bit n_stop, n_trig, n_pend, n_en;
    bw = bus_req && bus_wr;
    br = bus_req && !bus_wr;
    acc = m_ready() && trc_valid;
    adv = 0;
    n_cnt = m_cnt; n_stop = m_stop; n_trig = m_trig; n_pend = m_pend; n_en = m_en;
    if (bw && bus_addr == 12'h024) begin m_ram[m_wptr] = bus_wdata; adv = 1; end
    else if (acc) begin m_ram[m_wptr] = trc_data; adv = 1; end
    if (acc) begin
      if (!m_trig && trc_trig) begin
        n_trig = 1;
        if (m_b13 && m_cnt == 0) n_stop = 1;
      end else if (m_trig && m_b13) begin
        if (m_cnt != 0) n_cnt = m_cnt - 1;
        if (m_cnt == 1) n_stop = 1;
      end
    end
    if (m_pend && !acc) begin n_pend = 0; if (m_b12) n_stop = 1; end
    if (bw && bus_addr == 12'h018) begin m_wptr = int'(bus_wdata[3:0]) % DEPTH; m_full = 0; end
    else if (adv) begin
      if (m_wptr == DEPTH - 1) m_full = 1;
      m_wptr = (m_wptr + 1) % DEPTH;
    end
    if (bw && bus_addr == 12'h014) m_rptr = int'(bus_wdata[3:0]) % DEPTH;
    else if (br && bus_addr == 12'h010) m_rptr = (m_rptr + 1) % DEPTH;
    if (bw && bus_addr == 12'h01C) n_cnt = int'(bus_wdata[TRIG_W-1:0]);
    if (bw && bus_addr == 12'h020) begin
      n_en = bus_wdata[0];
      if (bus_wdata[0] && !m_en) begin n_stop = 0; n_trig = 0; end
    end
    if (bw && bus_addr == 12'h304) begin
      m_b12 = bus_wdata[12]; m_b13 = bus_wdata[13];
      if (bus_wdata[6]) n_pend = 1;
    end
    m_cnt = n_cnt; m_stop = n_stop; m_trig = n_trig; m_pend = n_pend; m_en = n_en;
  endtask

  // One clock: compare outputs against the model, then advance it
  task automatic cyc(string tag);
    #1;
    chk({tag, " ready"}, 32'(trc_ready), 32'(m_ready()));
    if (bus_req && !bus_wr) begin
      chk({tag, " rdata"}, bus_rdata, m_read(bus_addr));
      last_rd = bus_rdata;
    end
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(tag);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    cyc(tag);
    bus_req = 0;
  endtask

  task automatic stream(int n, logic [31:0] base, int trig_at, string tag);
    for (int i = 0; i < n; i++) begin
      trc_valid = 1; trc_data = base + 32'(i); trc_trig = (i == trig_at);
      cyc(tag);
    end
    trc_valid = 0; trc_trig = 0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", wd);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    trc_valid = 0; trc_data = '0; trc_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(12'h014, "R1 rptr"); chk("R1 rptr", last_rd, 0);
    rd(12'h018, "R1 wptr"); chk("R1 wptr", last_rd, 0);
    rd(12'h00C, "R1 stat"); chk("R1 stat", last_rd, 0);
    rd(12'h020, "R1 ctrl"); chk("R1 ctrl", last_rd, 0);
    rd(12'h01C, "R1 tcnt"); chk("R1 tcnt", last_rd, 0);
    rd(12'h304, "R1 fctrl"); chk("R1 fctrl", last_rd, 0);
    rd(12'h300, "R10 fstat"); chk("R10 fstat off", last_rd, 32'h2);
    // R2 depth
    rd(12'h004, "R2 depth"); chk("R2 depth", last_rd, 32'(DEPTH));

    // R6: input ignored while disabled
    trc_valid = 1; trc_data = 32'hDEAD; #1; chk("R6 disabled", 32'(trc_ready), 0);
    cyc("R6"); trc_valid = 0;
    rd(12'h018, "R6 wptr"); chk("R6 wptr unchanged", last_rd, 0);

    // R3/R4/R5/R12: fill without wrap via write-data port
    for (int i = 0; i < 5; i++) wr(12'h024, 32'hA0 + 32'(i), "R3 fill");
    rd(12'h018, "R3 wptr"); chk("R3 wptr", last_rd, 5);
    rd(12'h00C, "R5 stat"); chk("R5 no wrap full", last_rd[0], 0);
    chk("R12 unaligned", last_rd[3], 1);
    wr(12'h014, 0, "R4 rptr load");
    for (int i = 0; i < 5; i++) begin
      rd(12'h010, "R4 drain"); chk("R4 drain", last_rd, 32'hA0 + 32'(i));
    end
    rd(12'h014, "R4 rptr"); chk("R4 rptr", last_rd, 5);

    // R5/R6/R4: capture with wrap, oldest-first readback
    wr(12'h018, 0, "R5 wptr clr");
    wr(12'h020, 1, "R6 enable");
    stream(22, 32'h100, -1, "R6 stream");
    rd(12'h00C, "R5 stat"); chk("R5 full", last_rd[0], 1);
    rd(12'h018, "R5 wptr"); chk("R5 wptr", last_rd, 6);
    wr(12'h014, 6, "R4 rptr=wptr");
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'h010, "R4 oldest"); chk("R4 oldest first", last_rd, 32'h106 + 32'(i));
    end
    wr(12'h018, 8, "R5 wptr load");
    rd(12'h00C, "R5 stat"); chk("R5 full cleared", last_rd[0], 0);
    chk("R12 aligned", last_rd[3], 0);

    // R6: bus write to write-data blocks input
    trc_valid = 1; trc_data = 32'h55;
    bus_req = 1; bus_wr = 1; bus_addr = 12'h024; bus_wdata = 32'h77;
    #1; chk("R6 blocked", 32'(trc_ready), 0);
    cyc("R6 block"); bus_req = 0; bus_wr = 0; trc_valid = 0;

    // R7: stop on trigger, N = 3
    wr(12'h020, 0, "R7 disable");
    wr(12'h018, 0, "R7 wptr");
    wr(12'h01C, 3, "R7 tcnt");
    wr(12'h304, 32'h2000, "R7 fctrl");
    wr(12'h020, 1, "R7 enable");
    stream(10, 32'h200, 2, "R7 stream");
    rd(12'h018, "R7 wptr"); chk("R7 words stored", last_rd, 6);
    rd(12'h00C, "R7 stat"); chk("R7 stopped", last_rd[2], 1);
    rd(12'h01C, "R7 tcnt"); chk("R7 count spent", last_rd, 0);
    rd(12'h300, "R10 fstat"); chk("R10 stopped", last_rd[1], 1);
    wr(12'h014, 5, "R7 rptr");
    rd(12'h010, "R7 last"); chk("R7 last word", last_rd, 32'h205);

    // R11/R8: re-arm, trigger without stop
    wr(12'h304, 0, "R8 fctrl");
    wr(12'h01C, 2, "R8 tcnt");
    wr(12'h020, 0, "R11 off");
    wr(12'h020, 1, "R11 on");
    #1; chk("R11 ready again", 32'(trc_ready), 1);
    rd(12'h00C, "R11 stat"); chk("R11 flags clear", last_rd[2:1], 0);
    rd(12'h300, "R10 fstat"); chk("R10 running", last_rd[1], 0);
    stream(8, 32'h300, 1, "R8 stream");
    rd(12'h018, "R8 wptr"); chk("R8 no stop", last_rd, 14);
    rd(12'h00C, "R8 stat"); chk("R8 triggered", last_rd[2:1], 2'b01);
    rd(12'h01C, "R8 tcnt"); chk("R8 count kept", last_rd, 2);

    // R9: manual flush with stop-on-flush while beats flow
    trc_valid = 1; trc_data = 32'h400;
    wr(12'h304, 32'h1040, "R9 request");
    rd(12'h304, "R9 pending"); chk("R9 pending", last_rd[6], 1);
    trc_valid = 0;
    cyc("R9 idle");
    rd(12'h304, "R9 done"); chk("R9 bit6 cleared", last_rd[6], 0);
    rd(12'h300, "R9 fstat"); chk("R9 halted", last_rd[1], 1);
    rd(12'h00C, "R9 stat"); chk("R9 stopped", last_rd[2], 1);
    #1; chk("R9 ready low", 32'(trc_ready), 0);

    // R3/R5: wrap through the write-data port
    wr(12'h018, 15, "R3 wptr end");
    wr(12'h024, 32'hBEEF, "R3 wrap write");
    rd(12'h018, "R3 wptr wrap"); chk("R3 wrap to 0", last_rd, 0);
    rd(12'h00C, "R5 stat"); chk("R5 full via port", last_rd[0], 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule